// File: doc/BRIEF.md
# Multi-Flag Conditional Branch Unit

This unit decides whether a conditional branch is taken and forms its 16-bit target address. It is used in the execute path of an 8-bit accumulator processor. Its inputs are the four condition flags (N, V, Z, C), a 3-bit condition select taken from the branch opcode, two mode bits from prefix decoding, the address of the next instruction and a PC-relative displacement.

In plain mode, each condition select tests one flag against a value. When the compare-mode bit is set, the same eight select codes mean eight comparisons instead: four signed and four unsigned. These comparisons are read from the flags that a preceding compare leaves behind. That compare also updates V when it is 16 bits wide, so the signed tests stay valid after wide compares.

A second mode bit controls the displacement. When it is clear, only the low byte of the displacement is used and it is sign-extended. When it is set, all 16 bits are used. The two mode bits are independent, so both can be set at once. The decision and the target are purely combinational: both are valid in the same cycle as the inputs.

Top module: `branch_decide_unit`

## Requirements
- R1: With `cmp_mode_i`=0, the taken output for `cond_i` 0..7 is, in order: N==0, N==1, V==0, V==1, C==0, C==1, Z==0, Z==1.
- R2: With `cmp_mode_i`=1, `cond_i`=0 (signed less) is taken when N xor V, and `cond_i`=1 (signed greater-or-equal) is taken when N equals V.
- R3: With `cmp_mode_i`=1, `cond_i`=2 (signed less-or-equal) is taken when Z or (N xor V), and `cond_i`=3 (signed greater) is taken when neither holds.
- R4: With `cmp_mode_i`=1, `cond_i`=4 (unsigned lower) is taken when C=0, and `cond_i`=5 (unsigned higher-or-same) is taken when C=1.
- R5: With `cmp_mode_i`=1, `cond_i`=6 (unsigned lower-or-same) is taken when C=0 or Z=1, and `cond_i`=7 (unsigned higher) is taken when C=1 and Z=0.
- R6: With `long_disp_i`=0, the target is `next_pc_i` plus `disp_i[7:0]` sign-extended to 16 bits, and `disp_i[15:8]` has no effect.
- R7: With `long_disp_i`=1, the target is `next_pc_i` plus the full 16-bit `disp_i`.
- R8: The target addition wraps modulo 2^16 in both directions.
- R9: The target does not depend on the flags, `cond_i` or `cmp_mode_i`, and the taken output does not depend on `long_disp_i`, `next_pc_i` or `disp_i`.
- R10: Both outputs are combinational and are valid in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag (set means no borrow) |
| cond_i | input | 3 | Condition select from the branch opcode |
| cmp_mode_i | input | 1 | 1 selects the signed and unsigned compare conditions |
| long_disp_i | input | 1 | 1 selects the full 16-bit displacement |
| next_pc_i | input | 16 | Address of the instruction after the branch |
| disp_i | input | 16 | Displacement; only the low byte is used in short mode |
| taken_o | output | 1 | Branch condition is met |
| target_o | output | 16 | Branch target address |

## Verification
Both results are due in the same cycle as their stimulus, with no register in between. The bench therefore applies each input set just after a rising clock edge and samples the outputs at the following falling edge, which falls inside that same cycle. For the checks that some inputs have no effect, the bench changes only those inputs and samples again in the next half cycle. It expects the output to be unchanged.

// File: rtl/bru_pkg.sv
package bru_pkg;

    // Compare-mode condition codes; bit 0 of each pair selects the complement
    typedef enum logic [2:0] {
        CC_SLT = 3'd0,
        CC_SGE = 3'd1,
        CC_SLE = 3'd2,
        CC_SGT = 3'd3,
        CC_ULO = 3'd4,
        CC_UHS = 3'd5,
        CC_ULS = 3'd6,
        CC_UHI = 3'd7
    } cmp_cond_e;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  flags_t     flags_i,
    input  logic [2:0] cond_i,
    input  logic       cmp_mode_i,
    output logic       taken_o
);

    logic base_d;
    logic invert_d;
    logic sless_d;

    always_comb begin
        sless_d = flags_i.n ^ flags_i.v;
        if (cmp_mode_i) begin
            unique case (cond_i[2:1])
                2'b00:   base_d = sless_d;
                2'b01:   base_d = sless_d | flags_i.z;
                2'b10:   base_d = ~flags_i.c;
                default: base_d = ~flags_i.c | flags_i.z;
            endcase
            invert_d = cond_i[0];
        end else begin
            unique case (cond_i[2:1])
                2'b00:   base_d = flags_i.n;
                2'b01:   base_d = flags_i.v;
                2'b10:   base_d = flags_i.c;
                default: base_d = flags_i.z;
            endcase
            invert_d = ~cond_i[0];
        end
        taken_o = base_d ^ invert_d;
    end

    always_comb begin
        // R2
        sgn_lt_chk: assert (!(cmp_mode_i && cond_i == CC_SLT && taken_o) || (flags_i.n != flags_i.v))
            else $error("signed-less taken with N==V");
        // R5
        uns_hi_chk: assert (!(cmp_mode_i && cond_i == CC_UHI && taken_o) || (flags_i.c && !flags_i.z))
            else $error("unsigned-higher taken without C and not Z");
        // R3
        sgn_gt_chk: assert (!(cmp_mode_i && cond_i == CC_SGT && taken_o) || (!flags_i.z && flags_i.n == flags_i.v))
            else $error("signed-greater taken on equal or less");
        // R1
        plain_flag_chk: assert (cmp_mode_i || cond_i[2:1] != 2'b11 || taken_o == (flags_i.z == cond_i[0]))
            else $error("plain zero test mismatch");
    end

endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc #(
    parameter int ADDR_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [ADDR_W-1:0] disp_i,
    input  logic              long_disp_i,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] offset_d;
    logic [ADDR_W-1:0] diff_chk_d;

    always_comb begin
        if (long_disp_i)
            offset_d = disp_i;
        else
            offset_d = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
        target_o = next_pc_i + offset_d;
    end

    always_comb begin
        diff_chk_d = target_o - next_pc_i;
        // R7
        long_off_chk: assert (!long_disp_i || diff_chk_d == disp_i)
            else $error("long target offset mismatch");
        // R6
        short_off_chk: assert (long_disp_i ||
                               (diff_chk_d[SHORT_W-1:0] == disp_i[SHORT_W-1:0] &&
                                diff_chk_d[ADDR_W-1:SHORT_W] == {EXT_W{disp_i[SHORT_W-1]}}))
            else $error("short target offset mismatch");
    end

endmodule

// File: rtl/branch_decide_unit.sv
module branch_decide_unit
    import bru_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SHORT_W = 8
) (
    input  logic              flag_n_i,
    input  logic              flag_v_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic [2:0]        cond_i,
    input  logic              cmp_mode_i,
    input  logic              long_disp_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [ADDR_W-1:0] disp_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o
);

    flags_t flags_d;

    always_comb begin
        flags_d.n = flag_n_i;
        flags_d.v = flag_v_i;
        flags_d.z = flag_z_i;
        flags_d.c = flag_c_i;
    end

    bru_cond_eval u_cond (
        .flags_i    (flags_d),
        .cond_i     (cond_i),
        .cmp_mode_i (cmp_mode_i),
        .taken_o    (taken_o)
    );

    bru_target_calc #(
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W)
    ) u_tgt (
        .next_pc_i   (next_pc_i),
        .disp_i      (disp_i),
        .long_disp_i (long_disp_i),
        .target_o    (target_o)
    );

    always_comb begin
        // R4
        uns_lo_chk: assert (!(cmp_mode_i && cond_i == CC_ULO) || taken_o == !flag_c_i)
            else $error("unsigned-lower mismatch");
    end

endmodule

// File: tb/sim_branch_decide_unit.sv
module sim_branch_decide_unit;

    logic        clk = 1'b0;
    logic        n, v, z, c;
    logic [2:0]  cond;
    logic        cmode, ldisp;
    logic [15:0] npc, disp;
    logic        taken;
    logic [15:0] target;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    branch_decide_unit u0 (
        .flag_n_i    (n),
        .flag_v_i    (v),
        .flag_z_i    (z),
        .flag_c_i    (c),
        .cond_i      (cond),
        .cmp_mode_i  (cmode),
        .long_disp_i (ldisp),
        .next_pc_i   (npc),
        .disp_i      (disp),
        .taken_o     (taken),
        .target_o    (target)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    function automatic logic exp_plain(input logic [2:0] s, input logic fn, fv, fz, fc);
        case (s)
            3'd0: return !fn;
            3'd1: return fn;
            3'd2: return !fv;
            3'd3: return fv;
            3'd4: return !fc;
            3'd5: return fc;
            3'd6: return !fz;
            default: return fz;
        endcase
    endfunction

    function automatic logic exp_cmp(input logic [2:0] s, input logic fn, fv, fz, fc);
        logic lt;
        lt = (fn != fv);
        case (s)
            3'd0: return lt;
            3'd1: return !lt;
            3'd2: return fz || lt;
            3'd3: return !fz && !lt;
            3'd4: return !fc;
            3'd5: return fc;
            3'd6: return !fc || fz;
            default: return fc && !fz;
        endcase
    endfunction

    task automatic apply(input logic [3:0] f, input logic [2:0] s, input logic m,
                         input logic l, input logic [15:0] p, input logic [15:0] d);
        @(posedge clk);
        #1;
        {n, v, z, c} = f;
        cond = s; cmode = m; ldisp = l; npc = p; disp = d;
        @(negedge clk);
    endtask

    task automatic chk_taken(input string req, input logic exp);
        vectors++;
        if (taken !== exp) begin
            errors++;
            $display("FAIL %s: taken actual %b expected %b (flags %b cond %0d mode %b)",
                     req, taken, exp, {n, v, z, c}, cond, cmode);
        end
    endtask

    task automatic chk_target(input string req, input logic [15:0] exp);
        vectors++;
        if (target !== exp) begin
            errors++;
            $display("FAIL %s: target actual %h expected %h", req, target, exp);
        end
    endtask

    // R10: idle state, results due in the same cycle
    task automatic t_idle();
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000);
        chk_taken("R10", 1'b1);
        chk_target("R10", 16'h0000);
        apply(4'b1000, 3'd0, 1'b0, 1'b0, 16'h0000, 16'h0000);
        chk_taken("R10", 1'b0);
    endtask

    // R1: plain single-flag tests
    task automatic t_plain();
        for (int f = 0; f < 16; f++)
            for (int s = 0; s < 8; s++) begin
                apply(4'(f), 3'(s), 1'b0, 1'b0, 16'h1000, 16'h0010);
                chk_taken("R1", exp_plain(3'(s), f[3], f[2], f[1], f[0]));
            end
    endtask

    // R2 R3 R4 R5: compare-mode conditions
    task automatic t_compare();
        for (int f = 0; f < 16; f++)
            for (int s = 0; s < 8; s++) begin
                apply(4'(f), 3'(s), 1'b1, 1'b0, 16'h2000, 16'h0020);
                if (s < 2)      chk_taken("R2", exp_cmp(3'(s), f[3], f[2], f[1], f[0]));
                else if (s < 4) chk_taken("R3", exp_cmp(3'(s), f[3], f[2], f[1], f[0]));
                else if (s < 6) chk_taken("R4", exp_cmp(3'(s), f[3], f[2], f[1], f[0]));
                else            chk_taken("R5", exp_cmp(3'(s), f[3], f[2], f[1], f[0]));
            end
    endtask

    // R6: short displacement, sign-extended, upper byte ignored
    task automatic t_short();
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'h1234, 16'h0005);
        chk_target("R6", 16'h1239);
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'h1234, 16'h00FE);
        chk_target("R6", 16'h1232);
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'h1234, 16'hA57F);
        chk_target("R6", 16'h12B3);
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'h1234, 16'h5A80);
        chk_target("R6", 16'h11B4);
    endtask

    // R7: long displacement
    task automatic t_long();
        apply(4'b0000, 3'd0, 1'b0, 1'b1, 16'h1234, 16'h0100);
        chk_target("R7", 16'h1334);
        apply(4'b0000, 3'd0, 1'b0, 1'b1, 16'h1234, 16'hF000);
        chk_target("R7", 16'h0234);
        apply(4'b0000, 3'd0, 1'b1, 1'b1, 16'h4000, 16'h00FE);
        chk_target("R7", 16'h40FE);
    endtask

    // R8: wrap modulo 2^16
    task automatic t_wrap();
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'hFFF0, 16'h0020);
        chk_target("R8", 16'h0010);
        apply(4'b0000, 3'd0, 1'b0, 1'b0, 16'h0004, 16'h00F0);
        chk_target("R8", 16'hFFF4);
        apply(4'b0000, 3'd0, 1'b0, 1'b1, 16'h8000, 16'h9000);
        chk_target("R8", 16'h1000);
    endtask

    // R9: cross-independence of the two outputs
    task automatic t_indep();
        apply(4'b0101, 3'd3, 1'b1, 1'b0, 16'h3000, 16'h0040);
        chk_target("R9", 16'h3040);
        chk_taken("R9", 1'b0);
        #2;
        {n, v, z, c} = 4'b1010; cond = 3'd6; cmode = 1'b0;
        #2;
        chk_target("R9", 16'h3040);
        ldisp = 1'b1; npc = 16'h7777; disp = 16'hFFFF;
        #2;
        chk_taken("R9", 1'b0);
        cond = 3'd7;
        #2;
        chk_taken("R9", 1'b1);
    endtask

    initial begin
        {n, v, z, c} = 4'b0000;
        cond = 3'd0; cmode = 1'b0; ldisp = 1'b0; npc = '0; disp = '0;
        t_idle();
        t_plain();
        t_compare();
        t_short();
        t_long();
        t_wrap();
        t_indep();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule